// File: doc/BRIEF.md
# Pilot-Locked Fractional Sample-Clock Divider

This block derives a sample-rate clock enable (nominally 512 times a 19 kHz pilot, 9.728 MHz) from a faster system clock above 40 MHz. Because the input clock is not an integer multiple of the target rate, the enables are spaced unevenly. The gap between two enables takes one of two adjacent integer lengths, and the long-run average matches the target. A phase accumulator adds an increment every input cycle. Each wrap of the accumulator produces one single-cycle enable.

The nominal increment and a trim limit are written through a simple load strobe, so the same block can serve several system clock frequencies. An external pilot tracking loop supplies up and down pulses. Each pulse moves a signed trim by one increment LSB, and the trim saturates at a programmable symmetric limit. A preset input removes the trim from the increment at once, so the rate is nominal with no steering. On the following cycle it also clears the stored trim to zero. Preset is used for sources that carry no pilot.

Top module: `pilot_frac_divider`

## Requirements
- R1: While `rst_n` is low, `ce_out` is 0. After reset the nominal increment is `RST_INC` with zero trim, so the enable rate follows R2 with that increment.
- R2: With a constant effective increment `inc`, the number of enables in any N consecutive cycles is floor or ceil of N·inc/2^ACC_W. With the default registered output, `ce_out` is one cycle behind the accumulator step.
- R3: Consecutive enables are separated by either floor(2^ACC_W/inc) or ceil(2^ACC_W/inc) cycles, and each enable is one cycle wide.
- R4: A cycle with `cfg_wr` high loads `cfg_inc` as the nominal increment and `cfg_lim` as the trim limit. Both take effect from the next cycle.
- R5: With `preset` low, a cycle with `pulse_up` high and `pulse_dn` low raises the trim by one LSB of the increment.
- R6: With `preset` low, a cycle with `pulse_dn` high and `pulse_up` low lowers the trim by one LSB.
- R7: The trim stays within ±limit. Steps beyond the limit are absorbed. If the limit is lowered below the stored trim, the trim is pulled to the new bound on the next cycle.
- R8: A cycle with both `pulse_up` and `pulse_dn` high leaves the trim unchanged.
- R9: While `preset` is high, the effective increment equals the nominal increment in that same cycle, and up/down pulses have no effect on the trim.
- R10: A cycle with `preset` high clears the trim to zero on the next edge. This holds even if an up or down pulse arrives in the same cycle. After preset is released, the rate is nominal until new pulses arrive.
- R11: The effective increment, nominal plus trim, is clamped to the range 0 to 2^ACC_W−1.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (above 40 MHz in use) |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load strobe for nominal increment and trim limit |
| cfg_inc | input | ACC_W | Nominal phase increment |
| cfg_lim | input | TRIM_W | Symmetric trim limit (magnitude) |
| preset | input | 1 | Force nominal rate and clear the trim |
| pulse_up | input | 1 | Pilot loop request: one LSB faster |
| pulse_dn | input | 1 | Pilot loop request: one LSB slower |
| ce_out | output | 1 | Single-cycle sample-clock enable |

## Verification
Two groups of functions can land in the same cycle. In the first, the up and down steering pulses coincide. In the second, preset coincides with an up pulse while a nonzero trim is stored. The bench provokes both by raising the inputs on the same falling edge. It then judges the outcome only from the enable count over a 2^(ACC_W+1)-cycle window, where each trim LSB shifts the count by exactly two. Coincident up and down must leave the count where it was. Preset combined with up must return the count to the nominal value once preset drops.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_INC  = 2'd1,
      STEP_DEC  = 2'd2
   } step_e;
endpackage

// File: rtl/pfd_cfg.sv
module pfd_cfg #(
   parameter int                ACC_W   = 24,
   parameter int                TRIM_W  = 8,
   parameter logic [ACC_W-1:0]  RST_INC = '0,
   parameter logic [TRIM_W-1:0] RST_LIM = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ACC_W-1:0]  cfg_inc,
   input  logic [TRIM_W-1:0] cfg_lim,
   output logic [ACC_W-1:0]  nom_q,
   output logic [TRIM_W-1:0] lim_q
);
   // R4: setting registers, loaded by the strobe, visible next cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nom_q <= RST_INC;
         lim_q <= RST_LIM;
      end else if (cfg_wr) begin
         nom_q <= cfg_inc;
         lim_q <= cfg_lim;
      end
   end

   a_r4_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (nom_q == $past(cfg_inc)) && (lim_q == $past(cfg_lim)));
endmodule

// File: rtl/pfd_trim.sv
module pfd_trim
   import pfd_pkg::*;
#(
   parameter int TRIM_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     preset,
   input  logic                     pulse_up,
   input  logic                     pulse_dn,
   input  logic [TRIM_W-1:0]        lim,
   output logic signed [TRIM_W:0]   trim_q
);
   localparam int SW = TRIM_W + 2;

   step_e                step;
   logic signed [SW-1:0] trim_x;
   logic signed [SW-1:0] stepped;
   logic signed [SW-1:0] lim_p;
   logic signed [SW-1:0] lim_n;
   logic signed [SW-1:0] bounded;

   // R8: coincident requests cancel
   always_comb begin
      if (pulse_up && !pulse_dn)      step = STEP_INC;
      else if (pulse_dn && !pulse_up) step = STEP_DEC;
      else                            step = STEP_HOLD;
   end

   assign trim_x = {trim_q[TRIM_W], trim_q};
   assign lim_p  = $signed({2'b00, lim});
   assign lim_n  = -lim_p;

   // R5, R6: one LSB per request; R7: clamp to the current limit
   always_comb begin
      case (step)
         STEP_INC: stepped = trim_x + SW'(1);
         STEP_DEC: stepped = trim_x - SW'(1);
         default:  stepped = trim_x;
      endcase
      if (stepped > lim_p)      bounded = lim_p;
      else if (stepped < lim_n) bounded = lim_n;
      else                      bounded = stepped;
   end

   // R9, R10: preset overrides any request and zeroes the trim
   always_ff @(posedge clk) begin
      if (!rst_n)      trim_q <= '0;
      else if (preset) trim_q <= '0;
      else             trim_q <= bounded[TRIM_W:0];
   end

   a_r7_trim_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (trim_x <= $past(lim_p)) && (trim_x >= $past(lim_n)));

   a_r10_preset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      preset |=> (trim_q == '0));

   a_r8_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_up && pulse_dn && !preset && (lim == $past(lim))) |=> (trim_q == $past(trim_q)));
endmodule

// File: rtl/pfd_accum.sv
module pfd_accum #(
   parameter int ACC_W  = 24,
   parameter int TRIM_W = 8,
   parameter bit CE_REG = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   preset,
   input  logic [ACC_W-1:0]       nom,
   input  logic signed [TRIM_W:0] trim,
   output logic                   ce
);
   localparam int               EW      = ACC_W + 2;
   localparam int               XW      = EW - TRIM_W - 1;
   localparam logic [ACC_W-1:0] INC_MAX = '1;

   logic signed [EW-1:0] trim_ext;
   logic signed [EW-1:0] req;
   logic [ACC_W-1:0]     inc_eff;
   logic [ACC_W:0]       sum;
   logic [ACC_W-1:0]     acc_q;

   assign trim_ext = {{XW{trim[TRIM_W]}}, trim};

   // R9: preset drops the trim term; R11: clamp to the legal increment range
   always_comb begin
      req = $signed({2'b00, nom}) + (preset ? EW'(0) : trim_ext);
      if (req < 0)                               inc_eff = '0;
      else if (req > $signed({2'b00, INC_MAX}))  inc_eff = INC_MAX;
      else                                       inc_eff = req[ACC_W-1:0];
   end

   assign sum = {1'b0, acc_q} + {1'b0, inc_eff};

   always_ff @(posedge clk) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= sum[ACC_W-1:0];
   end

   generate
      if (CE_REG) begin : g_ce_reg
         logic ce_q;
         always_ff @(posedge clk) begin
            if (!rst_n) ce_q <= 1'b0;
            else        ce_q <= sum[ACC_W];
         end
         assign ce = ce_q;

         // R2, R3: an enable marks exactly the steps where the phase wrapped
         a_r3_wrap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (ce_q == (acc_q < $past(acc_q))));
      end else begin : g_ce_comb
         assign ce = sum[ACC_W];
      end
   endgenerate
endmodule

// File: rtl/pilot_frac_divider.sv
module pilot_frac_divider #(
   parameter int                ACC_W   = 24,
   parameter int                TRIM_W  = 8,
   parameter logic [ACC_W-1:0]  RST_INC = ACC_W'(3984589),
   parameter logic [TRIM_W-1:0] RST_LIM = TRIM_W'(64),
   parameter bit                CE_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ACC_W-1:0]  cfg_inc,
   input  logic [TRIM_W-1:0] cfg_lim,
   input  logic              preset,
   input  logic              pulse_up,
   input  logic              pulse_dn,
   output logic              ce_out
);
   generate
      if (ACC_W < 4 || ACC_W > 48) begin : g_bad_acc
         $error("pilot_frac_divider: ACC_W out of range");
      end
      if (TRIM_W < 1 || TRIM_W >= ACC_W) begin : g_bad_trim
         $error("pilot_frac_divider: TRIM_W must be 1..ACC_W-1");
      end
   endgenerate

   logic [ACC_W-1:0]        nom_q;
   logic [TRIM_W-1:0]       lim_q;
   logic signed [TRIM_W:0]  trim_q;

   pfd_cfg #(
      .ACC_W   (ACC_W),
      .TRIM_W  (TRIM_W),
      .RST_INC (RST_INC),
      .RST_LIM (RST_LIM)
   ) i_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_wr  (cfg_wr),
      .cfg_inc (cfg_inc),
      .cfg_lim (cfg_lim),
      .nom_q   (nom_q),
      .lim_q   (lim_q)
   );

   pfd_trim #(
      .TRIM_W (TRIM_W)
   ) i_trim (
      .clk      (clk),
      .rst_n    (rst_n),
      .preset   (preset),
      .pulse_up (pulse_up),
      .pulse_dn (pulse_dn),
      .lim      (lim_q),
      .trim_q   (trim_q)
   );

   pfd_accum #(
      .ACC_W  (ACC_W),
      .TRIM_W (TRIM_W),
      .CE_REG (CE_REG)
   ) i_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .preset (preset),
      .nom    (nom_q),
      .trim   (trim_q),
      .ce     (ce_out)
   );
endmodule

// File: tb/test_pilot_frac_divider.sv
module test_pilot_frac_divider;
   localparam int A    = 10;
   localparam int T    = 4;
   localparam int MOD  = 1 << A;
   localparam int WIN  = 2 * MOD;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_wr = 1'b0;
   logic [A-1:0] cfg_inc = '0;
   logic [T-1:0] cfg_lim = '0;
   logic         preset = 1'b0;
   logic         pulse_up = 1'b0;
   logic         pulse_dn = 1'b0;
   logic         ce_out;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #2 clk = ~clk;

   pilot_frac_divider #(
      .ACC_W   (A),
      .TRIM_W  (T),
      .RST_INC (10'd243),
      .RST_LIM (4'd5),
      .CE_REG  (1'b1)
   ) i_pilot_frac_divider (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .cfg_inc  (cfg_inc),
      .cfg_lim  (cfg_lim),
      .preset   (preset),
      .pulse_up (pulse_up),
      .pulse_dn (pulse_dn),
      .ce_out   (ce_out)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic write_cfg(input int inc, input int lim);
      @(negedge clk);
      cfg_wr  = 1'b1;
      cfg_inc = A'(inc);
      cfg_lim = T'(lim);
      @(negedge clk);
      cfg_wr  = 1'b0;
      settle();
   endtask

   task automatic up_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); pulse_up = 1'b1;
         @(negedge clk); pulse_up = 1'b0;
      end
      settle();
   endtask

   task automatic dn_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); pulse_dn = 1'b1;
         @(negedge clk); pulse_dn = 1'b0;
      end
      settle();
   endtask

   task automatic preset_pulse();
      @(negedge clk); preset = 1'b1;
      @(negedge clk); preset = 1'b0;
      settle();
   endtask

   // rate over WIN cycles must equal WIN*inc/MOD = 2*inc exactly; gaps checked too
   task automatic measure(input int inc, input string tag);
      int cnt = 0;
      int last = -1;
      int badgap = 0;
      int lo = (inc > 0) ? MOD / inc : 0;
      int hi = (inc > 0) ? lo + ((MOD % inc) != 0 ? 1 : 0) : 0;
      for (int i = 0; i < WIN; i++) begin
         @(negedge clk);
         if (ce_out) begin
            cnt++;
            if (last >= 0 && !((i - last) == lo || (i - last) == hi)) badgap = i - last;
            last = i;
         end
      end
      chk(cnt == 2 * inc, tag, cnt, 2 * inc);
      chk(badgap == 0, {"R3 gap under ", tag}, badgap, lo);
   endtask

   initial begin
      int sweep[5] = '{1, 243, 511, 1023, 700};
      // R1: quiet during reset, then reset default increment
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(ce_out == 1'b0, "R1 reset", int'(ce_out), 0);
      end
      rst_n = 1'b1;
      settle();
      measure(243, "R1 default rate");

      // R2, R4: nominal rates across the increment range
      foreach (sweep[k]) begin
         write_cfg(sweep[k], 5);
         measure(sweep[k], "R2 R4 nominal");
      end

      // R5, R7: up steps saturating at +5
      write_cfg(243, 5);
      for (int k = 1; k <= 7; k++) begin
         up_n(1);
         measure(243 + ((k < 5) ? k : 5), "R5 R7 up");
      end
      // R6, R7: down steps from +5 to saturation at -5
      for (int j = 1; j <= 12; j++) begin
         dn_n(1);
         measure(243 + ((5 - j > -5) ? 5 - j : -5), "R6 R7 down");
      end

      // R8: up and down together leave trim at -5
      @(negedge clk); pulse_up = 1'b1; pulse_dn = 1'b1;
      @(negedge clk); pulse_up = 1'b0; pulse_dn = 1'b0;
      settle();
      measure(238, "R8 coincident");

      // R9: held preset forces nominal, up requests ignored
      @(negedge clk); preset = 1'b1;
      up_n(2);
      measure(243, "R9 preset held");
      @(negedge clk); preset = 1'b0;
      settle();
      measure(243, "R9 after release");

      // R10: preset coincident with up while trim is +3
      up_n(3);
      measure(246, "R10 pre");
      @(negedge clk); preset = 1'b1; pulse_up = 1'b1;
      @(negedge clk); preset = 1'b0; pulse_up = 1'b0;
      settle();
      measure(243, "R10 preset+up");

      // R7: limit lowered below stored trim, then limit zero
      up_n(5);
      write_cfg(243, 2);
      measure(245, "R7 lowered limit");
      write_cfg(243, 0);
      measure(243, "R7 zero limit");
      up_n(1);
      measure(243, "R7 zero limit up");

      // R11: clamp high and clamp low
      write_cfg(1023, 5);
      up_n(3);
      measure(1023, "R11 clamp high");
      preset_pulse();
      write_cfg(2, 5);
      dn_n(5);
      measure(0, "R11 clamp low");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule